// File: doc/BRIEF.md
# Line Fault Watchdog Monitor

This block watches two digitized monitor inputs that sense the positive and negative halves of a line driver's output. Every clock cycle in which either input shows a one counts as a mark. A gap counter clocked by the transmit clock counts the cycles since the last mark. When the gap reaches a fixed threshold, the block pulls an open-drain fault line low. The fault indicator is modelled as a drive enable: when it is high the external pin is driven low, and when it is low the pin is left to its pull-up.

Once the fault is raised, it stays raised until two conditions both hold: a mark has been seen since the fault was raised, and a minimum hold of two clock periods has passed. Both monitor inputs pass through a two-stage synchronizer before mark detection, so every input change reaches the counter two clock edges late. The threshold, the minimum hold and the synchronizer depth are parameters. Their defaults are 192 cycles, 2 cycles and 2 stages.

Top module: `lf_watchdog`

## Requirements
- R1: After reset, with no mark seen, `fault_pull_en` rises at exactly the 192nd rising clock edge and not before.
- R2: A one on `mon_tip` alone, on `mon_ring` alone, or on both at once counts as a mark.
- R3: A monitor input passes two synchronizer flip-flops before it counts as a mark. A one applied before clock edge A, with the fault held long enough, releases the fault at edge A+2 and not earlier.
- R4: Each mark restarts the gap count from zero. A gap of 191 mark-free cycles followed by a mark never raises the fault.
- R5: Once raised, `fault_pull_en` stays high for at least two clock periods, even if a mark arrives right after it is raised.
- R6: With no mark, a raised fault stays raised indefinitely. Once the minimum hold has passed, the fault drops at the clock edge where the synchronized mark is seen.
- R7: While `rst_n` is low, `fault_pull_en` is low at once and the gap count is zero, even if a fault was raised before reset.
- R8: After a release, raising the fault again needs a fresh run of 192 mark-free cycles counted from the last mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_tip | input | 1 | Digitized monitor sense of the positive line half; 1 = mark |
| mon_ring | input | 1 | Digitized monitor sense of the negative line half; 1 = mark |
| fault_pull_en | output | 1 | 1 = drive the open-drain fault pin low; 0 = leave it high-impedance |

## Verification
The main function is exercised with mark-free gaps just below, at and above the threshold (191, 192, 193, 194, 195 cycles), and with very long and very short gaps. This separates an off-by-one in the threshold from a correct count. Gaps of 192 to 195 cycles place the releasing mark before, at and after the end of the two-cycle minimum hold, which shows whether release waits for the later of the two conditions. Marks arrive on tip only, ring only and both together, with widths of one to three cycles, so that either rail is shown to restart the count. A single-cycle pulse against a long-held fault measures the two-edge synchronizer latency, and a reset asserted during a fault shows the asynchronous release.

// File: rtl/lf_pkg.sv
package lf_pkg;
   typedef enum logic {
      LF_CLEAR = 1'b0,
      LF_HELD  = 1'b1
   } lf_state_e;
endpackage

// File: rtl/lf_sync.sv
module lf_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("lf_sync: W must be at least 1");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] sr [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) sr[i] <= '0;
            end else begin
               sr[0] <= d;
               for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lf_gap_counter.sv
module lf_gap_counter #(
   parameter int THRESH = 192,
   localparam int CW    = $clog2(THRESH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mark,
   output logic [CW-1:0] gap_cnt,
   output logic          gap_hit
);
   localparam logic [CW-1:0] LIMIT = CW'(THRESH);
   localparam logic [CW-1:0] LAST  = CW'(THRESH - 1);

   generate
      if (THRESH < 2) begin : g_bad_thresh
         $error("lf_gap_counter: THRESH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gap_cnt <= '0;
      else if (mark)             gap_cnt <= '0;
      else if (gap_cnt != LIMIT) gap_cnt <= gap_cnt + 1'b1;
   end

   assign gap_hit = !mark && (gap_cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst_n) begin
         p_cnt_bounded_r6: assert (gap_cnt <= LIMIT)
            else $error("gap count beyond threshold");
      end
   end

   p_clear_on_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mark |=> (gap_cnt == '0));

   p_step_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mark && gap_cnt != LIMIT) |=> (gap_cnt == $past(gap_cnt) + 1'b1));
endmodule

// File: rtl/lf_release_ctl.sv
module lf_release_ctl
   import lf_pkg::*;
#(
   parameter int HOLD_MIN = 2,
   localparam int HW      = (HOLD_MIN > 2) ? $clog2(HOLD_MIN) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mark,
   input  logic gap_hit,
   output logic fault
);
   localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_MIN - 1);

   lf_state_e     state;
   logic [HW-1:0] hold;
   logic          seen;

   generate
      if (HOLD_MIN < 2) begin : g_bad_hold
         $error("lf_release_ctl: HOLD_MIN must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LF_CLEAR;
         hold  <= '0;
         seen  <= 1'b0;
      end else begin
         unique case (state)
            LF_CLEAR: begin
               if (gap_hit) begin
                  state <= LF_HELD;
                  hold  <= '0;
                  seen  <= 1'b0;
               end
            end
            LF_HELD: begin
               if (hold == HOLD_LAST && (seen || mark)) begin
                  state <= LF_CLEAR;
               end else begin
                  if (hold != HOLD_LAST) hold <= hold + 1'b1;
                  seen <= seen | mark;
               end
            end
            default: state <= LF_CLEAR;
         endcase
      end
   end

   assign fault = (state == LF_HELD);

   p_min_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |=> fault);

   p_hold_no_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !mark && !seen) |=> fault);

   p_release_on_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && hold == HOLD_LAST && mark) |=> !fault);
endmodule

// File: rtl/lf_watchdog.sv
module lf_watchdog #(
   parameter int THRESH      = 192,
   parameter int HOLD_MIN    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mon_tip,
   input  logic mon_ring,
   output logic fault_pull_en
);
   localparam int CW = $clog2(THRESH + 1);

   logic [1:0]    mon_sync;
   logic          mark;
   logic [CW-1:0] gap_cnt;
   logic          gap_hit;
   logic          fault;

   lf_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mon_ring, mon_tip}),
      .q     (mon_sync)
   );

   assign mark = |mon_sync;

   lf_gap_counter #(.THRESH(THRESH)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .mark    (mark),
      .gap_cnt (gap_cnt),
      .gap_hit (gap_hit)
   );

   lf_release_ctl #(.HOLD_MIN(HOLD_MIN)) u_rel (
      .clk     (clk),
      .rst_n   (rst_n),
      .mark    (mark),
      .gap_hit (gap_hit),
      .fault   (fault)
   );

   assign fault_pull_en = fault;

   p_raise_after_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_hit && !fault) |=> fault_pull_en);

   p_raise_needs_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_pull_en) |-> ($past(gap_cnt) == CW'(THRESH - 1)));

   p_release_needs_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_pull_en) |-> (gap_cnt < CW'(HOLD_MIN)));
endmodule

// File: tb/tb_lf_watchdog.sv
module tb_lf_watchdog;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mon_tip = 1'b0;
   logic mon_ring = 1'b0;
   logic fault_pull_en;

   int vec_cnt = 0;
   int err_cnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lf_watchdog dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .mon_tip       (mon_tip),
      .mon_ring      (mon_ring),
      .fault_pull_en (fault_pull_en)
   );

   // Reference timeline built from the requirements: two-edge input delay,
   // raise after 192 mark-free edges, release needs a mark and two periods.
   int t, last_m, t_a;
   bit mf, p1, p2, m;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t = 0; last_m = 0; t_a = 0; mf = 0; p1 = 0; p2 = 0;
      end else begin
         m  = p2;
         p2 = p1;
         p1 = mon_tip | mon_ring;
         t  = t + 1;
         if (m) last_m = t;
         if (!mf) begin
            if (t - last_m >= 192) begin mf = 1; t_a = t; end
         end else if (t >= t_a + 2 && last_m > t_a) begin
            mf = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         vec_cnt++;
         if (fault_pull_en !== mf) begin
            err_cnt++;
            $display("FAIL cycle %0d (R1 R2 R4 R5 R6 R8): fault_pull_en actual %b expected %b",
                     t, fault_pull_en, mf);
         end
      end
   end

   task automatic check(input bit act, input bit exp, input string req);
      vec_cnt++;
      if (act !== exp) begin
         err_cnt++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // {idle cycles[19:4], ring, tip, mark width[1:0]}
   localparam int NV = 12;
   localparam logic [19:0] VEC [NV] = '{
      {16'd191, 1'b0, 1'b1, 2'd1},
      {16'd192, 1'b1, 1'b0, 2'd1},
      {16'd193, 1'b1, 1'b1, 2'd1},
      {16'd194, 1'b0, 1'b1, 2'd2},
      {16'd195, 1'b1, 1'b0, 2'd3},
      {16'd5,   1'b0, 1'b1, 2'd1},
      {16'd400, 1'b1, 1'b0, 2'd1},
      {16'd190, 1'b1, 1'b1, 2'd2},
      {16'd191, 1'b1, 1'b0, 2'd1},
      {16'd192, 1'b0, 1'b1, 2'd3},
      {16'd250, 1'b1, 1'b1, 2'd1},
      {16'd20,  1'b0, 1'b1, 2'd1}
   };

   task automatic finish_run();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      err_cnt++;
      $display("FAIL watchdog (R1): actual hung expected completion");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check(fault_pull_en, 1'b0, "R7 reset state");
      rst_n = 1'b1;

      // R1: exact raise edge counted from reset release
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!fault_pull_en && n < 300);
      vec_cnt++;
      if (n != 192) begin
         err_cnt++;
         $display("FAIL R1 raise edge: actual %0d expected 192", n);
      end

      // R3: single-cycle pulse, two synchronizer edges of latency
      repeat (10) @(negedge clk);
      mon_tip = 1'b1;
      @(negedge clk); mon_tip = 1'b0;
      check(fault_pull_en, 1'b1, "R3 latency edge A");
      @(negedge clk);
      check(fault_pull_en, 1'b1, "R3 latency edge A+1");
      @(negedge clk);
      check(fault_pull_en, 1'b0, "R3 release at edge A+2");

      // Table walk: gaps around the threshold and the hold window
      for (int i = 0; i < NV; i++) begin
         repeat (int'(VEC[i][19:4])) @(negedge clk);
         mon_tip  = VEC[i][2];
         mon_ring = VEC[i][3];
         repeat (int'(VEC[i][1:0])) @(negedge clk);
         mon_tip  = 1'b0;
         mon_ring = 1'b0;
      end

      // R7: reset during a raised fault releases at once
      repeat (200) @(negedge clk);
      check(fault_pull_en, 1'b1, "R6 held before reset");
      #1 rst_n = 1'b0;
      #1 check(fault_pull_en, 1'b0, "R7 async reset release");
      repeat (2) @(negedge clk);
      check(fault_pull_en, 1'b0, "R7 held in reset");
      rst_n = 1'b1;
      repeat (191) @(negedge clk);
      check(fault_pull_en, 1'b0, "R7 count restarted by reset");
      @(negedge clk);
      check(fault_pull_en, 1'b1, "R1 raise after reset restart");
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule